// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Acknowledge

The arbiter collects eight maskable interrupt request lines, a software-raised request and a non-maskable request. Each maskable source has a fixed priority level. Every cycle the arbiter picks the best pending request and compares its level with the priority the processor is running at. It raises a single interrupt line to the core only when that request is strictly more urgent. Requests that lose stay pending until the processor priority drops far enough.

The core takes an interrupt in two steps. It first pulses `entryStart` when it begins saving its context. It then pulses `ackStrobe` once the context is stored. On the acknowledge the arbiter returns the identifier of the source it selects at that moment, so a more urgent request that arrives during the entry sequence takes the place of the one that was first seen. A flag tells the core when this replacement happened. The software and non-maskable inputs are caught on their rising edges and are cleared by their own acknowledge. The maskable lines are level-sensitive and belong to the devices that drive them.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is held and after it is released, with no request present, `intReq`, `ackId` and `lateHit` are all 0.
- R2: Maskable source i (index 0..7) has identifier i+1. Its default level is i+1 for i<7, and source 7 has level 7. When a source's line is high, `intReq` rises on the first clock edge after that only if the source's level is strictly greater than `cpuLevel`. A request whose level is equal to or below `cpuLevel` keeps `intReq` low.
- R3: A masked request stays pending. When `cpuLevel` drops below the request's level, `intReq` rises on the next clock edge.
- R4: Among eligible requests, the highest level wins. When two maskable sources share a level, the lower index wins.
- R5: On a clock edge where `ackStrobe` is high, `ackId` takes the identifier of the winner registered before that edge, or 0 if `intReq` is low.
- R6: A rising edge on `nmiIn` is latched. One edge later it drives `intReq` high whatever `cpuLevel` is, up to 15, and it outranks every other request with identifier 15. The acknowledge that returns 15 clears the latched request.
- R7: A rising edge on `swReq` is latched as a request at level 2 with identifier 9. It loses a level tie to a maskable source. The acknowledge that returns 9 clears it.
- R8: An acknowledge does not clear a maskable request. A line that is still high stays pending and is returned again by the next acknowledge.
- R9: An `entryStart` pulse records the current winner as provisional. At the following acknowledge, `lateHit` becomes 1 if the returned identifier differs from the provisional one, and 0 otherwise. The returned identifier is the newer, higher-priority one.
- R10: `ackId` and `lateHit` change only on an acknowledge edge. Request changes after the acknowledge leave them untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 8 | Level-sensitive maskable request lines |
| swReq | input | 1 | Software request, rising-edge latched |
| nmiIn | input | 1 | Non-maskable request, rising-edge latched |
| cpuLevel | input | 4 | Current processor priority level |
| entryStart | input | 1 | Pulse: core begins service entry |
| ackStrobe | input | 1 | Pulse: acknowledge, identifier is captured |
| intReq | output | 1 | Interrupt request to the core |
| ackId | output | 4 | Identifier returned by the last acknowledge |
| lateHit | output | 1 | Last acknowledge replaced the provisional winner |

## Verification
The hardest case to reach from the ports is late arrival. The winner must change between the entry pulse and the acknowledge, and it must change in exactly the cycle in which the registered winner can already reflect the newer request. The bench holds a low-level line, pulses `entryStart`, and raises a higher-level line one cycle before the acknowledge. It then drops all requests and confirms that the returned identifier and the replacement flag stay frozen. The edge-latched inputs are driven with `cpuLevel` at its maximum so that only the non-maskable request can be seen. The bench then checks that, after its acknowledge, the line stays high but no new request appears.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef struct packed {
    logic ack;        // capture identifier this edge
    logic entry;      // capture provisional winner
    logic entryOpen;  // an entry is in progress
    logic clrNmi;     // drop latched non-maskable request
    logic clrSw;      // drop latched software request
  } arb_strobe_t;
endpackage

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W = 4,
  parameter int ID_W = 4,
  parameter logic [NUM_SRC*LVL_W-1:0] SRC_LEVEL = 32'h7765_4321,
  parameter int SW_LEVEL = 2,
  parameter int SW_ID = 9,
  parameter int NMI_ID = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               swReq,
  input  logic               nmiIn,
  input  logic [LVL_W-1:0]   cpuLevel,
  input  arb_strobe_t        strobes,
  output logic               winValid,
  output logic [ID_W-1:0]    winId,
  output logic [ID_W-1:0]    ackId,
  output logic               lateHit
);
  logic nmiPrev, swPrev, nmiPend, swPend;
  logic [LVL_W-1:0] bestLvl;
  logic [ID_W-1:0]  bestId, nextId, candId;
  logic             nextValid;

  always_comb begin
    bestLvl = '0;
    bestId  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (irqReq[i] && SRC_LEVEL[i*LVL_W +: LVL_W] > bestLvl) begin
        bestLvl = SRC_LEVEL[i*LVL_W +: LVL_W];
        bestId  = ID_W'(i + 1);
      end
    end
    if (swPend && LVL_W'(SW_LEVEL) > bestLvl) begin
      bestLvl = LVL_W'(SW_LEVEL);
      bestId  = ID_W'(SW_ID);
    end
    nextValid = bestLvl > cpuLevel;
    nextId    = nextValid ? bestId : '0;
    if (nmiPend) begin
      nextValid = 1'b1;
      nextId    = ID_W'(NMI_ID);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev  <= 1'b0;
      swPrev   <= 1'b0;
      nmiPend  <= 1'b0;
      swPend   <= 1'b0;
      winValid <= 1'b0;
      winId    <= '0;
      ackId    <= '0;
      candId   <= '0;
      lateHit  <= 1'b0;
    end else begin
      nmiPrev  <= nmiIn;
      swPrev   <= swReq;
      nmiPend  <= (nmiIn & ~nmiPrev) | (nmiPend & ~strobes.clrNmi);
      swPend   <= (swReq & ~swPrev) | (swPend & ~strobes.clrSw);
      winValid <= nextValid;
      winId    <= nextId;
      if (strobes.entry) candId <= winId;
      if (strobes.ack) begin
        ackId   <= winId;
        lateHit <= strobes.entryOpen && winValid && (winId != candId);
      end
    end
  end
endmodule

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
#(
  parameter int ID_W = 4,
  parameter int SW_ID = 9,
  parameter int NMI_ID = 15
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            entryStart,
  input  logic            ackStrobe,
  input  logic            winValid,
  input  logic [ID_W-1:0] winId,
  output arb_strobe_t     strobes
);
  logic entryActive;

  always_ff @(posedge clk) begin
    if (!rstN)           entryActive <= 1'b0;
    else if (ackStrobe)  entryActive <= 1'b0;
    else if (entryStart) entryActive <= 1'b1;
  end

  always_comb begin
    strobes.ack       = ackStrobe;
    strobes.entry     = entryStart && !ackStrobe;
    strobes.entryOpen = entryActive;
    strobes.clrNmi    = ackStrobe && winValid && (winId == ID_W'(NMI_ID));
    strobes.clrSw     = ackStrobe && winValid && (winId == ID_W'(SW_ID));
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W = 4,
  parameter int ID_W = 4,
  parameter logic [NUM_SRC*LVL_W-1:0] SRC_LEVEL = 32'h7765_4321,
  parameter int SW_LEVEL = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               swReq,
  input  logic               nmiIn,
  input  logic [LVL_W-1:0]   cpuLevel,
  input  logic               entryStart,
  input  logic               ackStrobe,
  output logic               intReq,
  output logic [ID_W-1:0]    ackId,
  output logic               lateHit
);
  localparam int SW_ID  = NUM_SRC + 1;
  localparam int NMI_ID = (1 << ID_W) - 1;

  arb_strobe_t     strobes;
  logic            winValid;
  logic [ID_W-1:0] winId;

  irq_arb_control #(.ID_W(ID_W), .SW_ID(SW_ID), .NMI_ID(NMI_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .entryStart(entryStart), .ackStrobe(ackStrobe),
    .winValid(winValid), .winId(winId), .strobes(strobes)
  );

  irq_arb_datapath #(
    .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ID_W(ID_W), .SRC_LEVEL(SRC_LEVEL),
    .SW_LEVEL(SW_LEVEL), .SW_ID(SW_ID), .NMI_ID(NMI_ID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .swReq(swReq), .nmiIn(nmiIn),
    .cpuLevel(cpuLevel), .strobes(strobes), .winValid(winValid),
    .winId(winId), .ackId(ackId), .lateHit(lateHit)
  );

  assign intReq = winValid;
endmodule

// File: rtl/irq_arbiter_checker.sv
module irq_arbiter_checker #(
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            nmiIn,
  input logic            ackStrobe,
  input logic            intReq,
  input logic [ID_W-1:0] ackId,
  input logic            lateHit
);
  assert_nmi_presented_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiIn) |=> ##1 intReq);
  assert_ack_valid_id_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && intReq) |=> (ackId != '0));
  assert_ack_empty_id_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !intReq) |=> (ackId == '0));
  assert_id_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ackStrobe |=> $stable(ackId));
  assert_late_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ackStrobe |=> $stable(lateHit));
endmodule

bind irq_arbiter irq_arbiter_checker #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .ackStrobe(ackStrobe),
  .intReq(intReq), .ackId(ackId), .lateHit(lateHit)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqReq = '0;
  logic       swReq = 1'b0, nmiIn = 1'b0, entryStart = 1'b0, ackStrobe = 1'b0;
  logic [3:0] cpuLevel = '0;
  logic       intReq, lateHit;
  logic [3:0] ackId;
  int checks = 0, errors = 0, cycles = 0;

  irq_arbiter uut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .swReq(swReq), .nmiIn(nmiIn),
    .cpuLevel(cpuLevel), .entryStart(entryStart), .ackStrobe(ackStrobe),
    .intReq(intReq), .ackId(ackId), .lateHit(lateHit)
  );

  always #5 clk = ~clk;

  // vector: {irqReq, cpuLevel, expected intReq, expected ackId}
  localparam logic [16:0] VEC [12] = '{
    {8'b0000_0001, 4'd0, 1'b1, 4'd1},  // R2 level 1 above 0
    {8'b0000_0001, 4'd1, 1'b0, 4'd0},  // R2 equal level masked
    {8'b0000_0100, 4'd2, 1'b1, 4'd3},  // R2
    {8'b0000_0100, 4'd3, 1'b0, 4'd0},  // R2
    {8'b1000_0000, 4'd6, 1'b1, 4'd8},  // R2 source 7
    {8'b1100_0000, 4'd0, 1'b1, 4'd7},  // R4 tie, lower index
    {8'b0010_1010, 4'd0, 1'b1, 4'd6},  // R4 highest level
    {8'b0010_1010, 4'd5, 1'b1, 4'd6},  // R4
    {8'b0010_1010, 4'd6, 1'b0, 4'd0},  // R2
    {8'b1111_1111, 4'd7, 1'b0, 4'd0},  // R2 all masked
    {8'b0000_0000, 4'd0, 1'b0, 4'd0},  // R5 no request
    {8'b0001_0001, 4'd2, 1'b1, 4'd5}   // R4
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doAck();
    ackStrobe = 1'b1;
    step(1);
    ackStrobe = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R1 intReq in reset", intReq, 0);
    check("R1 ackId in reset", ackId, 0);
    rstN = 1'b1;
    step(2);
    check("R1 intReq idle", intReq, 0);
    check("R1 lateHit idle", lateHit, 0);

    for (int v = 0; v < 12; v++) begin
      irqReq = VEC[v][16:9];
      cpuLevel = VEC[v][8:5];
      step(1);
      check($sformatf("R2 vec %0d intReq", v), intReq, VEC[v][4]);
      doAck();
      check($sformatf("R5 vec %0d ackId", v), ackId, VEC[v][3:0]);
      irqReq = '0;
      step(2);
    end

    // R3: masked request waits for priority drop
    irqReq = 8'b0000_0100; cpuLevel = 4'd5;
    step(2);
    check("R3 masked", intReq, 0);
    cpuLevel = 4'd2;
    step(1);
    check("R3 released", intReq, 1);
    irqReq = '0; cpuLevel = 4'd0;
    step(2);

    // R6: non-maskable beats everything at maximum cpuLevel
    cpuLevel = 4'd15; irqReq = 8'b0100_0000; nmiIn = 1'b1;
    step(1);
    check("R6 not yet", intReq, 0);
    step(1);
    check("R6 presented", intReq, 1);
    doAck();
    check("R6 ackId", ackId, 15);
    step(1);
    check("R6 cleared", intReq, 0);
    nmiIn = 1'b0; irqReq = '0;
    step(2);

    // R7: software request, level 2, id 9
    cpuLevel = 4'd1; swReq = 1'b1;
    step(2);
    check("R7 presented", intReq, 1);
    doAck();
    check("R7 ackId", ackId, 9);
    step(1);
    check("R7 cleared", intReq, 0);
    swReq = 1'b0; cpuLevel = 4'd0;
    step(1);
    swReq = 1'b1; irqReq = 8'b0000_0010;
    step(2);
    doAck();
    check("R7 tie lost to source 1", ackId, 2);
    irqReq = '0;
    step(1);
    doAck();
    check("R7 still pending", ackId, 9);
    swReq = 1'b0;
    step(2);

    // R8: maskable request survives acknowledge
    irqReq = 8'b0000_1000;
    step(1);
    doAck();
    check("R8 first ack", ackId, 4);
    step(2);
    check("R8 still requesting", intReq, 1);
    doAck();
    check("R8 second ack", ackId, 4);
    irqReq = '0;
    step(2);

    // R9: late arrival during entry
    irqReq = 8'b0000_0010;
    step(1);
    entryStart = 1'b1;
    step(1);
    entryStart = 1'b0;
    irqReq = 8'b0010_0010;
    step(1);
    doAck();
    check("R9 late winner", ackId, 6);
    check("R9 lateHit set", lateHit, 1);
    irqReq = '0;
    step(3);
    check("R10 ackId frozen", ackId, 6);
    check("R10 lateHit frozen", lateHit, 1);

    irqReq = 8'b0000_0100;
    step(1);
    entryStart = 1'b1;
    step(1);
    entryStart = 1'b0;
    step(1);
    doAck();
    check("R9 same winner", ackId, 3);
    check("R9 lateHit clear", lateHit, 0);
    irqReq = '0;
    step(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule